// File: doc/BRIEF.md
# Virtual Interrupt Masking Arbiter

This block decides, once per clock, whether a processor core running under a hypervisor must take an interrupt and which kind wins. It looks at three physical sources (normal, fast, asynchronous abort) and their three virtual counterparts, together with the current exception level, the security state, the per-kind mask bits and the hypervisor routing controls. Virtual eligibility follows one of two rule sets, a 64-bit-style one and a 32-bit-style one, picked by the `mode64` input.

The take flag and a six-bit one-hot winner are registered: they reflect the inputs sampled on the previous rising clock edge. Alongside, the block drives a combinational interrupt status word and a wake signal for a core sleeping in a wait-for-interrupt state. There is no data stream here; every pin is a plain level-sensitive control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `vima_arbiter`

## Requirements
- R1: Winner bit order is 0 physical normal, 1 virtual normal, 2 physical fast, 3 virtual fast, 4 physical abort, 5 virtual abort; when several are eligible the lowest-numbered bit wins, and `winner_o` never has more than one bit set.
- R2: Per-kind vectors use bit 0 for normal, bit 1 for fast, bit 2 for abort. A virtual normal or fast source is pending when its `virt_line` bit or its `inject` bit is 1; the virtual abort is pending only from `inject[2]`.
- R3: With `mode64`=1, no virtual source is eligible while `secure`=1 and `sec_hyp_en`=0.
- R4: With `mode64`=1, no virtual source is eligible when `trap_gen`=1, and a kind whose `route_ovr` bit is 0 is never eligible as virtual.
- R5: With `mode64`=1, override set and `trap_gen`=0, a virtual source is blocked at `el` 2 or 3; at `el` 0 or 1 it is eligible exactly when its `mask` bit is 0.
- R6: With `mode64`=0 and `trap_gen`=1, all three overrides read as 1 when `host_ext_present`=0 or `host_ext_bit`=0; otherwise the programmed `route_ovr` bits apply.
- R7: With `mode64`=0, a virtual source is eligible only when its mask bit is 0, its effective override is 1, `secure`=0 and `el` is not 2 (level 3 is allowed).
- R8: `status_o` bit 8 is abort, bit 7 normal, bit 6 fast, all other bits 0; each shows the virtual pending state when `el`<2, `el2_en`=1 and that kind's `route_ovr` bit is 1, and the physical pending line otherwise.
- R9: `wake_o` ignores masks: it is 1 when any `phys_pend` bit is 1, or when a virtual source is pending with its `route_ovr` bit set while `el`<2 and `el2_en`=1.
- R10: `reset_req` or `event_req` forces `take_o` to 1 on the next cycle even with no eligible source (winner then all zero); any winner bit implies `take_o`.
- R11: A physical source is eligible when its `phys_pend` bit is 1 and its `mask` bit is 0.
- R12: `take_o` and `winner_o` are 0 during reset and otherwise follow the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 1 selects the 64-bit rule set |
| el | input | 2 | Current exception level 0..3 |
| secure | input | 1 | Core is in the secure state |
| sec_hyp_en | input | 1 | Hypervisor level enabled in the secure state |
| el2_en | input | 1 | Hypervisor level enabled for the current state |
| trap_gen | input | 1 | Trap-general control |
| host_ext_present | input | 1 | Host-extension feature implemented |
| host_ext_bit | input | 1 | Host-extension control bit |
| route_ovr | input | 3 | Per-kind routing override |
| mask | input | 3 | Per-kind mask bits |
| phys_pend | input | 3 | Physical pending lines |
| virt_line | input | 2 | External virtual lines (normal, fast) |
| inject | input | 3 | Hypervisor-injected virtual requests |
| reset_req | input | 1 | Pending reset request |
| event_req | input | 1 | Pending send-event request |
| take_o | output | 1 | An interrupt must be taken (registered) |
| winner_o | output | 6 | One-hot winning source (registered) |
| status_o | output | 9 | Interrupt status word |
| wake_o | output | 1 | Wake from wait-for-interrupt |

## Verification
The bench targets the priority interleave, where a design that ranked all physical sources above virtual ones would pick the physical fast source over a pending virtual normal one. It walks the 64-bit table at its edges: secure with and without the secure-hypervisor enable, trap-general set, levels 2 and 3 against 0, so a gate missing the secure row or checking only level 2 would let a virtual source through. In 32-bit mode it exercises the override forcing with the host extension absent, present-and-clear and present-and-set, and level 3 as allowed, where a design reusing the 64-bit level rule would block it. Status and wake are driven with all masks set and with the virtual abort line absent, catching a status mux keyed on the effective rather than programmed override, or a wake that honours masks.

// File: rtl/vima_pkg.sv
package vima_pkg;
  localparam int NKIND    = 3;
  localparam int KIND_NRM = 0;
  localparam int KIND_FST = 1;
  localparam int KIND_ABT = 2;
  localparam int NLINE    = 2;
  localparam int NSRC     = 2 * NKIND;
  localparam int ELW      = 2;
  localparam int STAT_W   = 9;
  localparam logic [ELW-1:0] LVL_HYP = ELW'(2);

  // Status-word bit position for each kind: abort 8, normal 7, fast 6.
  function automatic int stat_pos(input int kind);
    case (kind)
      KIND_NRM: stat_pos = 7;
      KIND_FST: stat_pos = 6;
      default:  stat_pos = 8;
    endcase
  endfunction

  // Source index of a kind: physical at 2k, virtual at 2k+1.
  function automatic int src_idx(input int kind, input bit virt);
    src_idx = 2 * kind + (virt ? 1 : 0);
  endfunction
endpackage

// File: rtl/vima_virt_gate.sv
module vima_virt_gate
  import vima_pkg::*;
#(
  parameter int NK = NKIND
) (
  input  logic           mode64,
  input  logic [ELW-1:0] el,
  input  logic           secure,
  input  logic           sec_hyp_en,
  input  logic           trap_gen,
  input  logic           host_ext_present,
  input  logic           host_ext_bit,
  input  logic [NK-1:0]  route_ovr,
  input  logic [NK-1:0]  mask,
  output logic [NK-1:0]  allow
);
  logic force_ovr32;
  logic sec_lock64;
  logic high_lvl64;
  logic hyp_lvl32;

  assign force_ovr32 = trap_gen && (!host_ext_present || !host_ext_bit);
  assign sec_lock64  = secure && !sec_hyp_en;
  assign high_lvl64  = (el >= LVL_HYP);
  assign hyp_lvl32   = (el == LVL_HYP);

  for (genvar k = 0; k < NK; k++) begin : g_kind
    logic ovr32;
    logic ok32;
    logic ok64;

    assign ovr32 = force_ovr32 ? 1'b1 : route_ovr[k];

    // 32-bit rule set: one AND over mask, effective override, state, level.
    assign ok32 = !mask[k] && ovr32 && !secure && !hyp_lvl32;

    // 64-bit rule set: table walk, most restrictive rows first.
    always_comb begin
      if (sec_lock64)                    ok64 = 1'b0;
      else if (trap_gen || !route_ovr[k]) ok64 = 1'b0;
      else if (high_lvl64)               ok64 = 1'b0;
      else                               ok64 = !mask[k];
    end

    assign allow[k] = mode64 ? ok64 : ok32;

    always_comb begin
      if (mode64 && allow[k])
        assert_gate64_mask_R5: assert (!mask[k] && !high_lvl64);
      if (!mode64 && allow[k])
        assert_gate32_state_R7: assert (!secure && el != LVL_HYP);
    end
  end
endmodule

// File: rtl/vima_prio.sv
module vima_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  assign any = |req;

  always_comb begin
    assert_grant_onehot_R1: assert ($onehot0(grant));
    if (any) assert_grant_present_R1: assert (grant != '0);
  end
endmodule

// File: rtl/vima_status.sv
module vima_status
  import vima_pkg::*;
#(
  parameter int NK = NKIND,
  parameter int SW = STAT_W
) (
  input  logic [ELW-1:0] el,
  input  logic           el2_en,
  input  logic [NK-1:0]  route_ovr,
  input  logic [NK-1:0]  phys_pend,
  input  logic [NK-1:0]  virt_pend,
  output logic [SW-1:0]  status,
  output logic           wake
);
  logic          below_hyp;
  logic [NK-1:0] use_virt;
  logic [NK-1:0] virt_wake;

  assign below_hyp = (el < LVL_HYP) && el2_en;

  for (genvar k = 0; k < NK; k++) begin : g_sel
    assign use_virt[k]  = below_hyp && route_ovr[k];
    assign virt_wake[k] = use_virt[k] && virt_pend[k];
  end

  always_comb begin
    status = '0;
    for (int k = 0; k < NK; k++) begin
      status[stat_pos(k)] = use_virt[k] ? virt_pend[k] : phys_pend[k];
    end
  end

  assign wake = (|phys_pend) || (|virt_wake);

  always_comb begin
    if (|phys_pend) assert_wake_phys_R9: assert (wake);
  end
endmodule

// File: rtl/vima_arbiter.sv
module vima_arbiter
  import vima_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode64,
  input  logic [ELW-1:0]       el,
  input  logic                 secure,
  input  logic                 sec_hyp_en,
  input  logic                 el2_en,
  input  logic                 trap_gen,
  input  logic                 host_ext_present,
  input  logic                 host_ext_bit,
  input  logic [NKIND-1:0]     route_ovr,
  input  logic [NKIND-1:0]     mask,
  input  logic [NKIND-1:0]     phys_pend,
  input  logic [NLINE-1:0]     virt_line,
  input  logic [NKIND-1:0]     inject,
  input  logic                 reset_req,
  input  logic                 event_req,
  output logic                 take_o,
  output logic [NSRC-1:0]      winner_o,
  output logic [STAT_W-1:0]    status_o,
  output logic                 wake_o
);
  logic [NKIND-1:0] virt_pend;
  logic [NKIND-1:0] virt_allow;
  logic [NSRC-1:0]  src_req;
  logic [NSRC-1:0]  grant;
  logic             any_req;
  logic             take_d;
  logic             take_q;
  logic [NSRC-1:0]  win_q;

  // Pending virtual sources: lines exist only for the first NLINE kinds.
  for (genvar k = 0; k < NKIND; k++) begin : g_vpend
    if (k < NLINE) begin : g_line
      assign virt_pend[k] = virt_line[k] || inject[k];
    end else begin : g_inj
      assign virt_pend[k] = inject[k];
    end
  end

  vima_virt_gate #(.NK(NKIND)) u_gate (
    .mode64           (mode64),
    .el               (el),
    .secure           (secure),
    .sec_hyp_en       (sec_hyp_en),
    .trap_gen         (trap_gen),
    .host_ext_present (host_ext_present),
    .host_ext_bit     (host_ext_bit),
    .route_ovr        (route_ovr),
    .mask             (mask),
    .allow            (virt_allow)
  );

  // Interleave physical and virtual requests into priority order.
  for (genvar k = 0; k < NKIND; k++) begin : g_req
    assign src_req[src_idx(k, 1'b0)] = phys_pend[k] && !mask[k];
    assign src_req[src_idx(k, 1'b1)] = virt_pend[k] && virt_allow[k];
  end

  vima_prio #(.N(NSRC)) u_prio (
    .req   (src_req),
    .grant (grant),
    .any   (any_req)
  );

  vima_status #(.NK(NKIND), .SW(STAT_W)) u_status (
    .el        (el),
    .el2_en    (el2_en),
    .route_ovr (route_ovr),
    .phys_pend (phys_pend),
    .virt_pend (virt_pend),
    .status    (status_o),
    .wake      (wake_o)
  );

  assign take_d = any_req || reset_req || event_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      win_q  <= '0;
    end else begin
      take_q <= take_d;
      win_q  <= grant;
    end
  end

  assign take_o   = take_q;
  assign winner_o = win_q;

  assert_winner_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner_o));

  assert_winner_implies_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|winner_o) |-> take_o);

  assert_force_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || event_req) |=> take_o);

  assert_phys_normal_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_pend[KIND_NRM] && !mask[KIND_NRM]) |=> winner_o[0]);

  assert_secure_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode64 && secure && !sec_hyp_en) |=> !(winner_o[1] || winner_o[3] || winner_o[5]));

  assert_high_level_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode64 && el >= LVL_HYP) |=> !(winner_o[1] || winner_o[3] || winner_o[5]));

  assert_abort_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (el < LVL_HYP && el2_en && route_ovr[KIND_ABT]) |-> (status_o[8] == inject[KIND_ABT]));
endmodule

// File: tb/vima_arbiter_tb_top.sv
`timescale 1ns/1ps
module vima_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m64, sec, seh, e2en, tge, hxp, hxb, rr, ev;
  logic [1:0] el, vline;
  logic [2:0] ovr, msk, ppend, inj;
  logic       take_o, wake_o;
  logic [5:0] winner_o;
  logic [8:0] status_o;

  int checks = 0;
  int fails  = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  vima_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .mode64(m64), .el(el), .secure(sec),
    .sec_hyp_en(seh), .el2_en(e2en), .trap_gen(tge),
    .host_ext_present(hxp), .host_ext_bit(hxb), .route_ovr(ovr),
    .mask(msk), .phys_pend(ppend), .virt_line(vline), .inject(inj),
    .reset_req(rr), .event_req(ev), .take_o(take_o), .winner_o(winner_o),
    .status_o(status_o), .wake_o(wake_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic vpend_m(input int k);
    return (k == 2) ? inj[2] : (vline[k] | inj[k]);
  endfunction

  function automatic logic vok_m(input int k);
    if (m64) begin
      if (sec && !seh) return 1'b0;
      if (tge) return 1'b0;
      if (!ovr[k]) return 1'b0;
      if (el == 2'd2 || el == 2'd3) return 1'b0;
      return !msk[k];
    end else begin
      logic o;
      o = ovr[k];
      if (tge && (!hxp || !hxb)) o = 1'b1;
      return !msk[k] && o && !sec && (el != 2'd2);
    end
  endfunction

  // Compute expectations, check combinational outputs, queue registered ones.
  task automatic run_vec(input string tag);
    logic [5:0] elig, win;
    logic [8:0] st;
    logic       tk, wk, below;
    int         pos[3];
    pos[0] = 7; pos[1] = 6; pos[2] = 8;
    below = (el < 2'd2) && e2en;
    st = '0; wk = |ppend;
    for (int k = 0; k < 3; k++) begin
      elig[2*k]   = ppend[k] & ~msk[k];
      elig[2*k+1] = vpend_m(k) & vok_m(k);
      st[pos[k]]  = (below && ovr[k]) ? vpend_m(k) : ppend[k];
      if (below && ovr[k] && vpend_m(k)) wk = 1'b1;
    end
    win = '0;
    for (int i = 5; i >= 0; i--) if (elig[i]) win = 6'b1 << i;
    tk = (|elig) | rr | ev;
    if (!rst_n) begin tk = 1'b0; win = '0; end
    #0.2;
    chk(status_o == st, {tag, " status R8"}, status_o, st);
    chk(wake_o == wk, {tag, " wake R9"}, {8'b0, wake_o}, {8'b0, wk});
    exp_q.push_back({tk, win});
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  // Monitor: pops one expectation after each capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(winner_o == e[5:0], {t, " winner"}, {3'b0, winner_o}, {3'b0, e[5:0]});
        chk(take_o == e[6], {t, " take"}, {8'b0, take_o}, {8'b0, e[6]});
      end
    end
  end

  task automatic base();
    m64 = 1; sec = 0; seh = 0; e2en = 1; tge = 0; hxp = 0; hxb = 0; rr = 0; ev = 0;
    el = 2'd1; vline = '0; ovr = 3'b111; msk = '0; ppend = '0; inj = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    base();
    @(negedge clk); #1;
    ppend = 3'b111;
    run_vec("R12 reset holds outputs low");
    rst_n = 1'b1;
    base();
    run_vec("R12 idle");
    ppend = 3'b111;
    run_vec("R1 R11 all physical");
    ppend = 3'b110; inj[0] = 1;
    run_vec("R1 virtual normal beats physical fast");
    msk = 3'b001;
    run_vec("R11 masked normal");
    base(); ppend = 3'b100; inj = 3'b100;
    run_vec("R1 physical abort beats virtual abort");
    base(); vline = 2'b10;
    run_vec("R2 fast line pends");
    base(); vline = 2'b11; ovr = 3'b100; inj = 3'b000;
    run_vec("R2 abort needs inject");
    base(); inj = 3'b111; sec = 1; seh = 0;
    run_vec("R3 secure without enable");
    seh = 1;
    run_vec("R3 secure with enable");
    base(); inj = 3'b010; tge = 1;
    run_vec("R4 trap-general blocks");
    tge = 0; ovr = 3'b101;
    run_vec("R4 override clear blocks");
    base(); inj = 3'b100; el = 2'd2;
    run_vec("R5 level 2 blocks");
    el = 2'd3;
    run_vec("R5 level 3 blocks");
    el = 2'd0;
    run_vec("R5 level 0 takes");
    msk = 3'b100;
    run_vec("R5 mask blocks");
    base(); m64 = 0; tge = 1; ovr = 3'b000; inj = 3'b001;
    run_vec("R6 forced with host absent");
    hxp = 1; hxb = 1;
    run_vec("R6 programmed with host set");
    hxb = 0;
    run_vec("R6 forced with host bit clear");
    base(); m64 = 0; inj = 3'b010; sec = 1;
    run_vec("R7 secure blocks");
    sec = 0; el = 2'd2;
    run_vec("R7 level 2 blocks");
    el = 2'd3;
    run_vec("R7 level 3 allowed");
    base(); msk = 3'b111; inj = 3'b101; ppend = 3'b010; ovr = 3'b011;
    run_vec("R8 R9 mixed select masked");
    el = 2'd2;
    run_vec("R8 physical view at level 2");
    base(); e2en = 0; inj = 3'b111; msk = 3'b111;
    run_vec("R8 R9 level 2 disabled");
    base(); m64 = 0; tge = 1; ovr = 3'b000; inj = 3'b001;
    run_vec("R8 R9 programmed override for status");
    base(); rr = 1;
    run_vec("R10 reset request");
    rr = 0; ev = 1;
    run_vec("R10 event request");
    base(); ppend = 3'b001;
    rst_n = 1'b0;
    run_vec("R12 mid-run reset");
    rst_n = 1'b1;
    run_vec("R12 after reset");
    base();
    run_vec("R12 final idle");
    while (exp_q.size() > 0) @(negedge clk);
    summary();
  end
endmodule